// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Window

This block is a watchdog timer for a system controller. A prescaler divides the system clock down to a fixed tick of 0.6 seconds, and a 10-bit counter steps down by one on each tick. Software reaches the block through a 32-byte, byte-addressed window of 16-bit registers. Through this window it sets the timeout, clears a halt bit to start the count, and writes the reload register often enough that the count never runs out.

When the count runs out for the first time, the block sets a timeout flag and reloads itself. If it runs out again before software has cleared that flag, the block sets a second-timeout flag. It then raises a system reset request for four clock cycles, unless a no-reboot bit blocks it. A hardware strap can hold the no-reboot bit at one.

The reset-request path is a two-state machine. RQ_IDLE moves to RQ_PULSE when a second expiry occurs and reboot is allowed. RQ_PULSE counts four cycles and then returns to RQ_IDLE. A new second expiry while the machine is in RQ_PULSE restarts the count.

Top module: `countdown_watchdog`

## Requirements
- R1: After reset, control (0x08) reads 0x0801 (halt and no-reboot set), init (0x12) reads 0x0004, count (0x00) reads 4, both status registers read 0, and sys_rst_req is low.
- R2: While halt is 0, the count drops by one every TICK_CYC = CLK_HZ*6/10 clock cycles. The prescaler phase restarts on every reload write and is held at zero while the block is halted.
- R3: Bit 11 of control (0x08) is the halt bit and reads back as written. While it is 1, the count does not change except through a reload write.
- R4: Any 16-bit write to 0x00 loads the count from the init field. A read of 0x00 returns the count in bits [9:0], with bits [15:10] reading 0.
- R5: At 0x12, bits [9:0] form the init field and bits [15:10] are a separate stored field. A write whose bits [9:0] are 0 to 3 leaves the init field unchanged but still updates bits [15:10].
- R6: A tick that finds the count at 1 is an expiry. The count is reloaded from init, and status bit 3 at 0x04 is set.
- R7: An expiry while status bit 3 at 0x04 is already set also sets status bit 1 at 0x06. If reboot is allowed, sys_rst_req goes high at the next clock edge and stays high for exactly 4 cycles.
- R8: Writing 1 to bit 3 at 0x04 or to bit 1 at 0x06 clears that flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R9: Bit 0 of control is the no-reboot bit. When this bit is 1, or when strap_noreboot is 1, an expiry never raises sys_rst_req, but the status flags are still set. Readback of bit 0 shows the forced value.
- R10: Any address other than 0x00, 0x04, 0x06, 0x08 and 0x12, including odd addresses, reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wen | input | 1 | Write strobe for a 16-bit write at bus_addr |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| strap_noreboot | input | 1 | Strap that forces the no-reboot bit to 1 |
| sys_rst_req | output | 1 | Registered reset request pulse, active high |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of fault:
- **Ignored init values.** Writes of 0 to 3 must not change the init field. A design that stored them would reload with a value below four, or with zero.
- **Reload and tick in the same cycle.** A design that ignored the priority of the reload would count a spurious expiry.
- **Clear and expiry in the same cycle.** A design that let the clear win would lose a timeout and never escalate to the second flag.
- **Reset pulse length.** The pulse is measured cycle by cycle, so an off-by-one in the pulse state would show as three or five high cycles.
- **No-reboot gating.** This is checked both through the register bit and through the strap. A design that gated the flags instead of the request, or that missed the strap, shows up at once.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [4:0] OFF_RELOAD = 5'h00;
    localparam logic [4:0] OFF_STS_A  = 5'h04;
    localparam logic [4:0] OFF_STS_B  = 5'h06;
    localparam logic [4:0] OFF_CTRL   = 5'h08;
    localparam logic [4:0] OFF_INIT   = 5'h12;

    localparam int HALT_BIT  = 11;
    localparam int NOBOOT_BIT = 0;
    localparam int TOUT_BIT  = 3;
    localparam int TOUT2_BIT = 1;

    typedef enum logic {
        RQ_IDLE  = 1'b0,
        RQ_PULSE = 1'b1
    } rq_state_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    generate
        if (TICK_CYC > 1) begin : g_space
            // R2
            tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W   = 10,
    parameter int RST_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;

    assign count  = count_q;
    assign expire = tick && !reload && (count_q <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RST_VAL);
        end else if (reload || expire) begin
            count_q <= init_val;
        end else if (tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> $stable(count_q));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - 1'b1));

    // R6
    expire_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count_q == $past(init_val)));

endmodule

// File: rtl/wdt_rstreq_fsm.sv
module wdt_rstreq_fsm
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);
    localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    rq_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          req_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:  if (fire) state_d = RQ_PULSE;
            RQ_PULSE: if (!fire && cnt_q == LAST) state_d = RQ_IDLE;
            default:  state_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= (state_d == RQ_PULSE);
            if (fire)                      cnt_q <= '0;
            else if (state_q == RQ_PULSE)  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign req = req_q;

    logic [7:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_len <= '0;
        else if (!req_q)        run_len <= '0;
        else if (run_len != '1) run_len <= run_len + 1'b1;
    end

    // R7
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req_q);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> (run_len >= 8'(PULSE_LEN)));

endmodule

// File: rtl/countdown_watchdog.sv
module countdown_watchdog
    import wdt_pkg::*;
#(
    parameter int CLK_HZ    = 100,
    parameter int CNT_W     = 10,
    parameter int INIT_RST  = 4,
    parameter int INIT_MIN  = 4,
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        strap_noreboot,
    output logic        sys_rst_req
);
    localparam int TICK_RAW = (CLK_HZ * 6) / 10;
    localparam int TICK_CYC = (TICK_RAW > 0) ? TICK_RAW : 1;
    localparam int SPARE_W  = 16 - CNT_W;

    logic               halt_q, nr_q, tout1_q, tout2_q;
    logic [CNT_W-1:0]   init_q;
    logic [SPARE_W-1:0] spare_q;
    logic [CNT_W-1:0]   count;
    logic               tick, expire, fire, nr_eff;
    logic               wr_reload, wr_sts_a, wr_sts_b, wr_ctrl, wr_init, addr_known;

    assign wr_reload = bus_wen && (bus_addr == OFF_RELOAD);
    assign wr_sts_a  = bus_wen && (bus_addr == OFF_STS_A);
    assign wr_sts_b  = bus_wen && (bus_addr == OFF_STS_B);
    assign wr_ctrl   = bus_wen && (bus_addr == OFF_CTRL);
    assign wr_init   = bus_wen && (bus_addr == OFF_INIT);
    assign addr_known = (bus_addr == OFF_RELOAD) || (bus_addr == OFF_STS_A) ||
                        (bus_addr == OFF_STS_B)  || (bus_addr == OFF_CTRL)  ||
                        (bus_addr == OFF_INIT);

    assign nr_eff = nr_q | strap_noreboot;
    assign fire   = expire && tout1_q && !nr_eff;

    wdt_prescaler #(.TICK_CYC(TICK_CYC)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(!halt_q), .restart(wr_reload), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W), .RST_VAL(INIT_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reload(wr_reload),
        .init_val(init_q), .count(count), .expire(expire)
    );

    wdt_rstreq_fsm #(.PULSE_LEN(PULSE_LEN)) u_rq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .req(sys_rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q  <= 1'b1;
            nr_q    <= 1'b1;
            init_q  <= CNT_W'(INIT_RST);
            spare_q <= '0;
        end else begin
            if (wr_ctrl) begin
                halt_q <= bus_wdata[HALT_BIT];
                nr_q   <= bus_wdata[NOBOOT_BIT];
            end
            if (wr_init) begin
                spare_q <= bus_wdata[15:CNT_W];
                if (bus_wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN))
                    init_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tout1_q <= 1'b0;
            tout2_q <= 1'b0;
        end else begin
            tout1_q <= expire | (tout1_q & !(wr_sts_a & bus_wdata[TOUT_BIT]));
            tout2_q <= (expire & tout1_q) | (tout2_q & !(wr_sts_b & bus_wdata[TOUT2_BIT]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_RELOAD: bus_rdata[CNT_W-1:0] = count;
            OFF_STS_A:  bus_rdata[TOUT_BIT]  = tout1_q;
            OFF_STS_B:  bus_rdata[TOUT2_BIT] = tout2_q;
            OFF_CTRL: begin
                bus_rdata[HALT_BIT]   = halt_q;
                bus_rdata[NOBOOT_BIT] = nr_eff;
            end
            OFF_INIT:   bus_rdata = {spare_q, init_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R5
    init_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_init && bus_wdata[CNT_W-1:0] < CNT_W'(INIT_MIN)) |=> $stable(init_q));

    // R9
    noreboot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> !$past(nr_eff));

    // R7
    second_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout2_q) |-> $past(tout1_q));

    // R10
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && !addr_known) |=> $stable({halt_q, nr_q, init_q, spare_q}));

endmodule

// File: tb/countdown_watchdog_test.sv
`timescale 1ns/1ps
module countdown_watchdog_test;

    localparam int CLK_HZ = 20;
    localparam int TICK   = (CLK_HZ * 6) / 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        strap_noreboot = 1'b0;
    logic        sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    countdown_watchdog #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_noreboot(strap_noreboot), .sys_rst_req(sys_rst_req)
    );

    // Reference model of the requirements, updated at each rising edge
    logic       m_halt, m_nr, m_f1, m_f2;
    logic [9:0] m_init, m_cnt, n_cnt;
    logic [5:0] m_spare;
    int         m_pc, m_rq;
    logic       m_tick, m_exp, m_w0, m_w4, m_w6, m_w8, m_w12, m_nre;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_halt = 1; m_nr = 1; m_init = 10'd4; m_spare = '0;
            m_f1 = 0; m_f2 = 0; m_cnt = 10'd4; m_pc = 0; m_rq = 0;
        end else begin
            m_w0  = bus_wen && bus_addr == 5'h00;
            m_w4  = bus_wen && bus_addr == 5'h04;
            m_w6  = bus_wen && bus_addr == 5'h06;
            m_w8  = bus_wen && bus_addr == 5'h08;
            m_w12 = bus_wen && bus_addr == 5'h12;
            m_tick = !m_halt && (m_pc == TICK - 1);
            m_nre = m_nr | strap_noreboot;
            m_exp = 0;
            if (m_w0) n_cnt = m_init;
            else if (m_tick) begin
                if (m_cnt <= 1) begin n_cnt = m_init; m_exp = 1; end
                else n_cnt = m_cnt - 1;
            end else n_cnt = m_cnt;
            m_pc = (m_w0 || m_halt) ? 0 : ((m_pc == TICK - 1) ? 0 : m_pc + 1);
            if (m_exp && m_f1 && !m_nre) m_rq = 4;
            else if (m_rq > 0) m_rq = m_rq - 1;
            m_f2 = (m_exp & m_f1) | (m_f2 & !(m_w6 & bus_wdata[1]));
            m_f1 = m_exp | (m_f1 & !(m_w4 & bus_wdata[3]));
            m_cnt = n_cnt;
            if (m_w8) begin m_halt = bus_wdata[11]; m_nr = bus_wdata[0]; end
            if (m_w12) begin
                m_spare = bus_wdata[15:10];
                if (bus_wdata[9:0] >= 10'd4) m_init = bus_wdata[9:0];
            end
        end
    end

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        logic [15:0] v;
        v = '0;
        case (a)
            5'h00: v[9:0] = m_cnt;
            5'h04: v[3] = m_f1;
            5'h06: v[1] = m_f2;
            5'h08: begin v[11] = m_halt; v[0] = m_nr | strap_noreboot; end
            5'h12: v = {m_spare, m_init};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00: return "R4";
            5'h04: return "R6";
            5'h06: return "R7";
            5'h08: return "R3";
            5'h12: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // continuous reset-request comparison (R7, R9)
    bit watch_rq = 1'b0;
    always @(negedge clk) begin
        if (watch_rq && rst_n) chk("R7_R9 rst_req", 16'(sys_rst_req), 16'(m_rq > 0));
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_model(input logic [4:0] a);
        bus_addr = a;
        #1;
        chk(tag_of(a), bus_rdata, exp_read(a));
    endtask

    task automatic rd_lit(input logic [4:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
    endtask

    task automatic rdv(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // watch count for n cycles, return number of high cycles of the request
    task automatic run_watch(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sys_rst_req) highs++;
            rd_model(5'h00);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int highs;
        logic [15:0] v1, v2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        watch_rq = 1'b1;

        // R1 reset state
        rd_lit(5'h08, 16'h0801, "R1 ctrl");
        rd_lit(5'h12, 16'h0004, "R1 init");
        rd_lit(5'h00, 16'h0004, "R1 count");
        rd_lit(5'h04, 16'h0000, "R1 sts_a");
        rd_lit(5'h06, 16'h0000, "R1 sts_b");
        chk("R1 rst_req", 16'(sys_rst_req), 16'h0);

        // R5 ignored low values, upper field kept
        wr(5'h12, 16'hFC02);
        rd_lit(5'h12, 16'hFC04, "R5 ignore");
        wr(5'h12, 16'h0003);
        rd_lit(5'h12, 16'h0004, "R5 upper");
        wr(5'h12, 16'h0006);
        rd_lit(5'h12, 16'h0006, "R5 accept");

        // R10 undefined addresses
        wr(5'h0A, 16'hFFFF);
        wr(5'h13, 16'hFFFF);
        rd_lit(5'h0A, 16'h0000, "R10 read");
        rd_lit(5'h01, 16'h0000, "R10 odd");
        rd_lit(5'h08, 16'h0801, "R10 no effect");

        // R2 R4 R6 R7 two expiries with reboot allowed
        wr(5'h08, 16'h0000);
        wr(5'h00, 16'h1234);
        rd_lit(5'h00, 16'h0006, "R4 reload");
        run_watch(170, highs);
        chk("R7 pulse length", 16'(highs), 16'd4);
        rd_lit(5'h04, 16'h0008, "R6 flag");
        rd_lit(5'h06, 16'h0002, "R7 flag");

        // R8 write-one-to-clear
        wr(5'h04, 16'h0000);
        rd_lit(5'h04, 16'h0008, "R8 zero keeps");
        wr(5'h04, 16'h0008);
        rd_lit(5'h04, 16'h0000, "R8 clear a");
        wr(5'h06, 16'h0002);
        rd_lit(5'h06, 16'h0000, "R8 clear b");

        // R9 no-reboot via register bit
        wr(5'h08, 16'h0001);
        wr(5'h00, 16'h0000);
        run_watch(170, highs);
        chk("R9 no pulse reg", 16'(highs), 16'd0);
        rd_lit(5'h06, 16'h0002, "R9 flag still set");
        wr(5'h04, 16'h0008);
        wr(5'h06, 16'h0002);

        // R9 no-reboot via strap
        wr(5'h08, 16'h0000);
        @(negedge clk); strap_noreboot = 1'b1;
        rd_lit(5'h08, 16'h0001, "R9 strap readback");
        wr(5'h00, 16'h0000);
        run_watch(170, highs);
        chk("R9 no pulse strap", 16'(highs), 16'd0);
        @(negedge clk); strap_noreboot = 1'b0;

        // R3 halt freezes count
        wr(5'h08, 16'h0800);
        rd_lit(5'h08, 16'h0800, "R3 readback");
        rdv(5'h00, v1);
        repeat (60) @(negedge clk);
        rdv(5'h00, v2);
        chk("R3 frozen", v2, v1);

        // Constrained random phase
        for (int it = 0; it < 800; it++) begin
            int op;
            logic [15:0] d;
            op = $urandom % 8;
            case (op)
                0: wr(5'h00, 16'($urandom));
                1: begin
                    d = '0;
                    d[11] = (($urandom % 4) == 0);
                    d[0]  = (($urandom % 2) == 0);
                    wr(5'h08, d);
                end
                2: begin
                    d = 16'($urandom);
                    d[9:0] = 10'($urandom % 12);
                    wr(5'h12, d);
                end
                3: wr(5'h04, 16'($urandom));
                4: wr(5'h06, 16'($urandom));
                5: wr(5'($urandom), 16'($urandom));
                6: begin @(negedge clk); strap_noreboot = ~strap_noreboot; end
                default: @(negedge clk);
            endcase
            for (int k = 0; k < int'($urandom % 16); k++) begin
                @(negedge clk);
                rd_model(5'($urandom));
            end
            @(negedge clk);
            rd_model(5'h00);
        end

        done = 1'b1;
        watch_rq = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule